// File: doc/BRIEF.md
# MSR Load/Store List Sequencer

This block runs through a list of model-specific-register entries kept in memory whenever a virtual-machine transition asks for it. A start pulse supplies a mode, a 16-byte-aligned base address and an entry count. The sequencer then handles the entries one at a time, from the lowest address up. In store mode it reads the MSR that an entry names and writes that value back into the entry. In either load mode it writes the entry's value into the named MSR.

Each entry is 128 bits. Bits 31:0 carry the MSR index, bits 63:32 are not interpreted, and bits 127:64 carry the 64-bit value. Two MSR indices come in as inputs and are treated as write-protected: a load entry that names either one is passed over without any MSR write. A single-cycle done pulse marks the end of a walk. When a request is malformed, an error flag rises together with that pulse.

Top module: `msr_list_walker`

## Requirements
- R1: While reset is held, and after it until a start, done_o, err_o, mem_req_o, msr_rd_o and msr_wr_o are all low.
- R2: A start with count_i equal to 0 in a valid mode with an aligned base raises done_o on the cycle after start, with err_o low and no memory or MSR request.
- R3: A start whose base_i bits 3:0 are not all zero raises done_o and err_o together on the cycle after start, and no entry is read or written.
- R4: mode_i encodes 2'b00 store, 2'b01 exit-time load and 2'b10 entry-time load. The value 2'b11 is reserved and is handled like R3: error with done and no traffic.
- R5: Entries are read at base, base+16, base+32 and so on, in ascending order, one entry at a time. A memory request is held until mem_ack_i. The memory port and the MSR port are never active in the same cycle.
- R6: In store mode each entry is written back to its own address. Bits 127:64 of the written data hold the value returned for the MSR named in bits 31:0, and bits 63:0 are written back unchanged.
- R7: In a load mode the MSR named by entry bits 31:0 is written with entry bits 127:64. Bits 63:32 have no effect, and memory is never written.
- R8: The exit-time and entry-time load modes give identical MSR results and write counts for the same list.
- R9: In a load mode an entry whose index equals blk_idx_a_i or blk_idx_b_i causes no MSR write, and the walk carries on with the next entry.
- R10: After the last entry's final acknowledge, done_o is high for exactly one cycle with err_o low.
- R11: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| mode_i | input | 2 | 00 store, 01 exit load, 10 entry load, 11 reserved |
| base_i | input | ADDR_W | Byte address of the first entry |
| count_i | input | CNT_W | Number of entries |
| blk_idx_a_i | input | 32 | First write-protected MSR index |
| blk_idx_b_i | input | 32 | Second write-protected MSR index |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Entry address |
| mem_wdata_o | output | 128 | Entry written back in store mode |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata_i | input | 128 | Entry read data |
| msr_rd_o | output | 1 | MSR read request, held until acknowledge |
| msr_wr_o | output | 1 | MSR write request, held until acknowledge |
| msr_idx_o | output | 32 | MSR index for the current access |
| msr_wdata_o | output | 64 | MSR write value |
| msr_ack_i | input | 1 | MSR acknowledge; read data valid with it |
| msr_rdata_i | input | 64 | MSR read data |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Malformed request, high with done_o |

## Verification
The case that is hardest to reach from the ports is a protected index turning up in the middle of a load list, because only a missing write shows that it happened. The bench fills memory so that consecutive entries name MSRs 0 through 7, and it ties the two protected inputs to indices 3 and 5. It then compares the MSR file and the number of write acknowledges with a model, and it does this for both load modes. A second start pulse fired partway through a store walk checks that a running walk cannot be restarted.

// File: rtl/msrl_pkg.sv
package msrl_pkg;

    localparam int IDX_W       = 32;
    localparam int VAL_W       = 64;
    localparam int ENTRY_W     = 128;
    localparam int ENTRY_BYTES = ENTRY_W / 8;
    localparam int ALIGN_W     = $clog2(ENTRY_BYTES);
    localparam int VAL_LSB     = ENTRY_W - VAL_W;

    typedef enum logic [1:0] {
        MODE_STORE    = 2'b00,
        MODE_LD_EXIT  = 2'b01,
        MODE_LD_ENTRY = 2'b10,
        MODE_RSVD     = 2'b11
    } list_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ENT,
        ST_MSR_RD,
        ST_MSR_WR,
        ST_WR_ENT
    } walk_st_e;

endpackage

// File: rtl/msrl_cursor.sv
module msrl_cursor
    import msrl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ENTRY_BYTES);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (load_i) begin
            cur_d.addr = base_i;
            cur_d.left = count_i;
        end else if (step_i) begin
            cur_d.addr = cur_q.addr + STRIDE;
            cur_d.left = cur_q.left - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign addr_o = cur_q.addr;
    assign last_o = (cur_q.left == ONE);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cur_q.left != '0));

endmodule

// File: rtl/msrl_guard.sv
module msrl_guard
    import msrl_pkg::*;
#(
    parameter int N_BLK = 2
) (
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [N_BLK-1:0][IDX_W-1:0] blk_i,
    output logic                        hit_o
);

    logic [N_BLK-1:0] match;

    for (genvar g = 0; g < N_BLK; g++) begin : g_cmp
        assign match[g] = (idx_i == blk_i[g]);
    end

    assign hit_o = |match;

endmodule

// File: rtl/msr_list_walker.sv
module msr_list_walker
    import msrl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         mode_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic [31:0]        blk_idx_a_i,
    input  logic [31:0]        blk_idx_b_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [127:0]       mem_wdata_o,
    input  logic               mem_ack_i,
    input  logic [127:0]       mem_rdata_i,
    output logic               msr_rd_o,
    output logic               msr_wr_o,
    output logic [31:0]        msr_idx_o,
    output logic [63:0]        msr_wdata_o,
    input  logic               msr_ack_i,
    input  logic [63:0]        msr_rdata_i,
    output logic               done_o,
    output logic               err_o
);

    localparam int N_BLK = 2;

    typedef struct packed {
        walk_st_e           st;
        logic               is_load;
        logic [ENTRY_W-1:0] entry;
        logic               done;
        logic               err;
    } walk_t;

    walk_t walk_d, walk_q;

    logic              cur_load;
    logic              cur_step;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_last;
    logic              blk_hit;
    logic              bad_align;
    logic              bad_mode;

    logic [N_BLK-1:0][IDX_W-1:0] blk_set;
    assign blk_set = {blk_idx_b_i, blk_idx_a_i};

    msrl_cursor #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cur_load),
        .base_i  (base_i),
        .count_i (count_i),
        .step_i  (cur_step),
        .addr_o  (cur_addr),
        .last_o  (cur_last)
    );

    msrl_guard #(
        .N_BLK (N_BLK)
    ) u_guard (
        .idx_i (walk_q.entry[IDX_W-1:0]),
        .blk_i (blk_set),
        .hit_o (blk_hit)
    );

    assign bad_align = (base_i[ALIGN_W-1:0] != '0);
    assign bad_mode  = (list_mode_e'(mode_i) == MODE_RSVD);

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        walk_d.err  = 1'b0;
        cur_load    = 1'b0;
        cur_step    = 1'b0;

        unique case (walk_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (bad_mode || bad_align) begin
                        walk_d.done = 1'b1;
                        walk_d.err  = 1'b1;
                    end else if (count_i == '0) begin
                        walk_d.done = 1'b1;
                    end else begin
                        cur_load       = 1'b1;
                        walk_d.is_load = (list_mode_e'(mode_i) != MODE_STORE);
                        walk_d.st      = ST_RD_ENT;
                    end
                end
            end
            ST_RD_ENT: begin
                if (mem_ack_i) begin
                    walk_d.entry = mem_rdata_i;
                    walk_d.st    = walk_q.is_load ? ST_MSR_WR : ST_MSR_RD;
                end
            end
            ST_MSR_RD: begin
                if (msr_ack_i) begin
                    walk_d.entry[ENTRY_W-1:VAL_LSB] = msr_rdata_i;
                    walk_d.st                        = ST_WR_ENT;
                end
            end
            ST_MSR_WR: begin
                if (blk_hit || msr_ack_i) begin
                    cur_step    = 1'b1;
                    walk_d.st   = cur_last ? ST_IDLE : ST_RD_ENT;
                    walk_d.done = cur_last;
                end
            end
            ST_WR_ENT: begin
                if (mem_ack_i) begin
                    cur_step    = 1'b1;
                    walk_d.st   = cur_last ? ST_IDLE : ST_RD_ENT;
                    walk_d.done = cur_last;
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, is_load: 1'b0, entry: '0, done: 1'b0, err: 1'b0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign mem_req_o   = (walk_q.st == ST_RD_ENT) || (walk_q.st == ST_WR_ENT);
    assign mem_we_o    = (walk_q.st == ST_WR_ENT);
    assign mem_addr_o  = cur_addr;
    assign mem_wdata_o = walk_q.entry;
    assign msr_rd_o    = (walk_q.st == ST_MSR_RD);
    assign msr_wr_o    = (walk_q.st == ST_MSR_WR) && !blk_hit;
    assign msr_idx_o   = walk_q.entry[IDX_W-1:0];
    assign msr_wdata_o = walk_q.entry[ENTRY_W-1:VAL_LSB];
    assign done_o      = walk_q.done;
    assign err_o       = walk_q.err;

    // R5
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && (msr_rd_o || msr_wr_o)));

    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[ALIGN_W-1:0] == '0));

    // R6
    wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> $stable(mem_addr_o));

    // R6
    wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && $past(msr_rd_o && msr_ack_i))
        |-> (mem_wdata_o[127:64] == $past(msr_rdata_i)));

    // R9
    blk_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msr_wr_o |-> ((msr_idx_o != blk_idx_a_i) && (msr_idx_o != blk_idx_b_i)));

    // R2
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && walk_q.st == ST_IDLE && !bad_mode && !bad_align && count_i == '0)
        |=> (done_o && !err_o && !mem_req_o));

    // R3
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !mem_req_o && !msr_rd_o && !msr_wr_o));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/sim_msr_list_walker.sv
`timescale 1ns/1ps
module sim_msr_list_walker;

    localparam logic [31:0] MEM_BASE = 32'h0000_1000;
    localparam logic [31:0] BLK_A    = 32'hC000_0003;
    localparam logic [31:0] BLK_B    = 32'hC000_0005;

    // mode[15:14], first slot[13:8], count[7:0]
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 6'd2,  8'd5},
        {2'd1, 6'd0,  8'd8},
        {2'd2, 6'd0,  8'd8},
        {2'd0, 6'd20, 8'd1},
        {2'd2, 6'd30, 8'd3},
        {2'd0, 6'd40, 8'd16}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n;
    logic         start_i;
    logic [1:0]   mode_i;
    logic [31:0]  base_i;
    logic [8:0]   count_i;
    logic         mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0]  mem_addr_o;
    logic [127:0] mem_wdata_o, mem_rdata_i;
    logic         msr_rd_o, msr_wr_o, msr_ack_i;
    logic [31:0]  msr_idx_o;
    logic [63:0]  msr_wdata_o, msr_rdata_i;
    logic         done_o, err_o;

    msr_list_walker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .base_i(base_i), .count_i(count_i),
        .blk_idx_a_i(BLK_A), .blk_idx_b_i(BLK_B),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .msr_rd_o(msr_rd_o), .msr_wr_o(msr_wr_o), .msr_idx_o(msr_idx_o),
        .msr_wdata_o(msr_wdata_o), .msr_ack_i(msr_ack_i), .msr_rdata_i(msr_rdata_i),
        .done_o(done_o), .err_o(err_o)
    );

    logic [127:0] mem [64];
    logic [63:0]  msrf [16];
    logic [127:0] exp_mem [64];
    logic [63:0]  exp_msr [16];

    int n_chk = 0, n_err = 0;
    int rd_cnt = 0, mwr_cnt = 0, blk_wr = 0, done_cnt = 0, ord_err = 0, cycles = 0;
    logic [31:0] exp_rd_addr = '0;

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack_i <= 1'b0;
        if (rst_n && mem_req_o && !mem_ack_i) begin
            mem_ack_i <= 1'b1;
            if (mem_we_o) begin
                mem[(mem_addr_o - MEM_BASE) >> 4] <= mem_wdata_o;
            end else begin
                mem_rdata_i <= mem[(mem_addr_o - MEM_BASE) >> 4];
                rd_cnt <= rd_cnt + 1;
                if (mem_addr_o != exp_rd_addr) ord_err <= ord_err + 1;
                exp_rd_addr <= exp_rd_addr + 32'd16;
            end
        end
    end

    // MSR model
    always @(posedge clk) begin
        msr_ack_i <= 1'b0;
        if (rst_n && (msr_rd_o || msr_wr_o) && !msr_ack_i) begin
            msr_ack_i <= 1'b1;
            if (msr_wr_o) begin
                msrf[msr_idx_o[3:0]] <= msr_wdata_o;
                mwr_cnt <= mwr_cnt + 1;
                if (msr_idx_o == BLK_A || msr_idx_o == BLK_B) blk_wr <= blk_wr + 1;
            end else begin
                msr_rdata_i <= msrf[msr_idx_o[3:0]];
            end
        end
    end

    always @(posedge clk) begin
        if (done_o) done_cnt <= done_cnt + 1;
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int v);
        for (int s = 0; s < 64; s++) begin
            mem[s] = {32'hDA7A_0000 | 32'(v), 32'(s) * 32'h0101_0101,
                      32'hFEED_0000 | 32'(s), 32'hC000_0000 | 32'(s % 16)};
        end
        for (int i = 0; i < 16; i++) begin
            msrf[i] = {32'h5EED_0000 | 32'(v), 32'(i) * 32'h0011_0011};
        end
    endtask

    task automatic kick(input logic [1:0] m, input logic [31:0] b, input logic [8:0] c);
        @(negedge clk);
        mode_i = m; base_i = b; count_i = c; start_i = 1'b1;
        exp_rd_addr = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int cyc, output bit got_err);
        cyc = 1;
        while (!done_o && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        got_err = err_o;
    endtask

    initial begin
        int cyc, rd0, wr0, dn0;
        bit  e;
        rst_n = 1'b0; start_i = 1'b0; mode_i = '0; base_i = '0; count_i = '0;
        mem_ack_i = 1'b0; msr_ack_i = 1'b0; mem_rdata_i = '0; msr_rdata_i = '0;
        fill(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done_o && !err_o && !mem_req_o && !msr_rd_o && !msr_wr_o, "R1",
              "outputs in reset", {done_o, err_o, mem_req_o, msr_rd_o, msr_wr_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done_o && !mem_req_o && !msr_rd_o && !msr_wr_o, "R1",
              "idle after reset", {done_o, mem_req_o, msr_rd_o, msr_wr_o}, 0);

        // vector table
        for (int v = 0; v < 6; v++) begin
            logic [1:0] m;
            int slot, cnt, nwr;
            string rq;
            int bad_m, bad_r;
            m = VEC[v][15:14]; slot = int'(VEC[v][13:8]); cnt = int'(VEC[v][7:0]);
            rq = (m == 2'd0) ? "R6" : ((m == 2'd1) ? "R7" : "R8");
            fill(v);
            for (int s = 0; s < 64; s++) exp_mem[s] = mem[s];
            for (int i = 0; i < 16; i++) exp_msr[i] = msrf[i];
            nwr = 0;
            for (int k = 0; k < cnt; k++) begin
                int s;
                logic [31:0] ix;
                s = slot + k;
                ix = 32'hC000_0000 | 32'(s % 16);
                if (m == 2'd0) begin
                    exp_mem[s][127:64] = msrf[s % 16];
                end else if (ix != BLK_A && ix != BLK_B) begin
                    exp_msr[s % 16] = mem[s][127:64];
                    nwr++;
                end
            end
            rd0 = rd_cnt; wr0 = mwr_cnt; ord_err = 0; blk_wr = 0;
            kick(m, MEM_BASE + 32'(slot * 16), 9'(cnt));
            wait_done(cyc, e);
            check(done_o && !e, "R10", "done without error", {done_o, e}, 2'b10);
            @(negedge clk);
            check(!done_o, "R10", "done single pulse", done_o, 0);
            check(ord_err == 0, "R5", "ascending address order", ord_err, 0);
            check(rd_cnt - rd0 == cnt, "R5", "entries read", rd_cnt - rd0, cnt);
            bad_m = -1; bad_r = -1;
            for (int s = 0; s < 64; s++) if (mem[s] !== exp_mem[s] && bad_m < 0) bad_m = s;
            for (int i = 0; i < 16; i++) if (msrf[i] !== exp_msr[i] && bad_r < 0) bad_r = i;
            check(bad_m < 0, rq, "memory image",
                  (bad_m < 0) ? 128'd0 : mem[bad_m], (bad_m < 0) ? 128'd0 : exp_mem[bad_m]);
            check(bad_r < 0, rq, "MSR file",
                  (bad_r < 0) ? 128'd0 : 128'(msrf[bad_r]), (bad_r < 0) ? 128'd0 : 128'(exp_msr[bad_r]));
            if (m != 2'd0) begin
                check(mwr_cnt - wr0 == nwr, "R9", "MSR write count", mwr_cnt - wr0, nwr);
                check(blk_wr == 0, "R9", "protected index written", blk_wr, 0);
            end
        end

        // R2 zero count
        rd0 = rd_cnt; wr0 = mwr_cnt;
        kick(2'd0, MEM_BASE, 9'd0);
        check(done_o && !err_o, "R2", "zero count done next cycle", {done_o, err_o}, 2'b10);
        @(negedge clk);
        check(rd_cnt == rd0 && mwr_cnt == wr0 && !mem_req_o, "R2", "zero count traffic",
              rd_cnt - rd0, 0);

        // R3 misaligned base
        kick(2'd1, MEM_BASE + 32'h8, 9'd4);
        check(done_o && err_o, "R3", "misaligned error with done", {done_o, err_o}, 2'b11);
        @(negedge clk);
        check(rd_cnt == rd0 && !mem_req_o, "R3", "misaligned no traffic", rd_cnt - rd0, 0);

        // R4 reserved mode
        kick(2'd3, MEM_BASE, 9'd2);
        check(done_o && err_o, "R4", "reserved mode error", {done_o, err_o}, 2'b11);
        @(negedge clk);
        check(rd_cnt == rd0 && mwr_cnt == wr0 && !mem_req_o, "R4", "reserved mode no traffic",
              rd_cnt - rd0, 0);

        // R11 start while busy
        fill(9);
        rd0 = rd_cnt; dn0 = done_cnt;
        kick(2'd0, MEM_BASE + 32'(50 * 16), 9'd4);
        repeat (3) @(negedge clk);
        mode_i = 2'd0; base_i = MEM_BASE; count_i = 9'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o, "R11", "restart ignored early", done_o, 0);
        wait_done(cyc, e);
        repeat (20) @(negedge clk);
        check(done_cnt - dn0 == 1, "R11", "single done", done_cnt - dn0, 1);
        check(rd_cnt - rd0 == 4, "R11", "all entries walked", rd_cnt - rd0, 4);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule